// File: doc/BRIEF.md
# Slice Correlation Matrix Accumulator

This block builds a 12x12 complex correlation matrix from twelve parallel complex slice streams. A controller reads the finished matrix to decide which slices carry energy. The block only accumulates. Finding the support and inverting the matrix happen elsewhere.

One set of twelve complex samples is accepted at a time. The set is held in a register. On the next cycle, twelve complex multipliers update a single matrix row with the products of that row's slice and the conjugate of every slice. The active row advances by one for each accepted set and wraps after the last row. Input readiness therefore drops for one cycle after each acceptance.

A host programs how many sample sets to take and pulses start. It then waits for done and reads entries back through an addressed read port. A clear pulse returns the block to its empty state.

Top module: `slice_corr_acc`

## Requirements
- R1: After reset, done and in_ready are 0 and every matrix entry reads back as zero.
- R2: A start pulse, given while the block is neither running nor done, latches target and makes in_ready 1 from the next cycle on. A target of zero raises done at once instead.
- R3: For an accepted set s, with active row r, each entry (r,j) is updated as follows. The real part adds Re(s_r)Re(s_j)+Im(s_r)Im(s_j). The imaginary part adds Im(s_r)Re(s_j)-Re(s_r)Im(s_j). Samples enter as signed 16-bit fields, where slice i occupies bits [16i+15:16i] of in_re and in_im.
- R4: The active row starts at 0, advances by one per accepted set, and wraps from 11 back to 0.
- R5: In the cycle after a set is accepted, in_ready is 0.
- R6: Done rises in the cycle after the update of the target-th accepted set. While done is high, in_ready stays 0 and input has no effect on the matrix.
- R7: Each real or imaginary sum saturates at 2^39-1 and at -2^39 instead of wrapping.
- R8: A clear pulse zeros the matrix, the set count, the active row and done, and stops the run. Clear wins over start.
- R9: rd_re and rd_im show the entry addressed by rd_row and rd_col one cycle after the address is presented. Out-of-range addresses return zero.
- R10: Diagonal entries always have a zero imaginary part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an accumulation run |
| clear | input | 1 | Empty the matrix and stop |
| target | input | 16 | Number of sample sets per run |
| in_valid | input | 1 | Sample set present |
| in_ready | output | 1 | Block can accept a sample set |
| in_re | input | 192 | Real parts, slice i at bits [16i+15:16i] |
| in_im | input | 192 | Imaginary parts, same layout |
| done | output | 1 | Run has reached its target |
| rd_row | input | 4 | Read row address |
| rd_col | input | 4 | Read column address |
| rd_re | output | 40 | Real part of the addressed entry |
| rd_im | output | 40 | Imaginary part of the addressed entry |

## Verification
The assertions check the handshake and the flags on every cycle. They confirm that ready drops after each acceptance, that done holds until a clear and excludes ready, that a clear empties the flags, and that a diagonal read returns a zero imaginary part. The bench scenarios alone can show the arithmetic. These include the row rotation and its wrap, the conjugate products, saturation after long runs of full-scale samples, and a matrix left untouched by input offered after done.

// File: rtl/slice_corr_acc.sv
`timescale 1ns/1ps
module slice_corr_acc #(
  parameter int N     = 12,
  parameter int W     = 16,
  parameter int ACC_W = 40,
  parameter int CNT_W = 16,
  localparam int RW   = $clog2(N),
  localparam int PW   = 2*W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    clear,
  input  logic [CNT_W-1:0]        target,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N*W-1:0]          in_re,
  input  logic [N*W-1:0]          in_im,
  output logic                    done,
  input  logic [RW-1:0]           rd_row,
  input  logic [RW-1:0]           rd_col,
  output logic signed [ACC_W-1:0] rd_re,
  output logic signed [ACC_W-1:0] rd_im
);

  localparam logic signed [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_re [N][N];
  logic signed [ACC_W-1:0] acc_im [N][N];
  logic signed [PW-1:0]    h_re [N];
  logic signed [PW-1:0]    h_im [N];
  logic signed [PW-1:0]    p_re [N];
  logic signed [PW-1:0]    p_im [N];
  logic signed [PW-1:0]    a_re, a_im;
  logic                    busy, running;
  logic [RW-1:0]           row;
  logic [CNT_W-1:0]        cnt, tgt;

  wire accept = in_valid & in_ready;
  assign in_ready = running & ~busy;

  function automatic logic signed [ACC_W-1:0] sat_add(
      input logic signed [ACC_W-1:0] a, input logic signed [PW-1:0] b);
    logic signed [ACC_W:0] s;
    s = (ACC_W+1)'(a) + (ACC_W+1)'(b);
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? SAT_MIN : SAT_MAX;
    return s[ACC_W-1:0];
  endfunction

  assign a_re = h_re[row];
  assign a_im = h_im[row];

  for (genvar j = 0; j < N; j++) begin : g_mul
    assign p_re[j] = a_re * h_re[j] + a_im * h_im[j];
    assign p_im[j] = a_im * h_re[j] - a_re * h_im[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; running <= 1'b0; done <= 1'b0;
      row <= '0; cnt <= '0; tgt <= '0;
      for (int i = 0; i < N; i++) begin
        h_re[i] <= '0; h_im[i] <= '0;
        for (int j = 0; j < N; j++) begin
          acc_re[i][j] <= '0; acc_im[i][j] <= '0;
        end
      end
    end else if (clear) begin
      busy <= 1'b0; running <= 1'b0; done <= 1'b0;
      row <= '0; cnt <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          acc_re[i][j] <= '0; acc_im[i][j] <= '0;
        end
    end else begin
      if (start && !running && !done) begin
        tgt <= target;
        if (target == '0) done <= 1'b1;
        else running <= 1'b1;
      end
      if (accept) begin
        busy <= 1'b1;
        cnt  <= cnt + 1'b1;
        for (int i = 0; i < N; i++) begin
          h_re[i] <= PW'($signed(in_re[i*W +: W]));
          h_im[i] <= PW'($signed(in_im[i*W +: W]));
        end
      end
      if (busy) begin
        busy <= 1'b0;
        for (int j = 0; j < N; j++) begin
          acc_re[row][j] <= sat_add(acc_re[row][j], p_re[j]);
          acc_im[row][j] <= sat_add(acc_im[row][j], p_im[j]);
        end
        row <= (row == RW'(N-1)) ? '0 : row + 1'b1;
        if (cnt == tgt) begin
          done <= 1'b1; running <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_re <= '0; rd_im <= '0;
    end else if (rd_row < RW'(N) && rd_col < RW'(N)) begin
      rd_re <= acc_re[rd_row][rd_col];
      rd_im <= acc_im[rd_row][rd_col];
    end else begin
      rd_re <= '0; rd_im <= '0;
    end
  end

endmodule

// File: rtl/slice_corr_acc_chk.sv
`timescale 1ns/1ps
module slice_corr_acc_chk #(
  parameter int RW    = 4,
  parameter int ACC_W = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    done,
  input logic [RW-1:0]           rd_row,
  input logic [RW-1:0]           rd_col,
  input logic signed [ACC_W-1:0] rd_im
);

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clear |=> done);

  p_done_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !done && !in_ready);

  p_diag_real_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_row == rd_col |=> rd_im == '0);

endmodule

bind slice_corr_acc slice_corr_acc_chk #(.RW(RW), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .in_ready(in_ready), .done(done), .rd_row(rd_row), .rd_col(rd_col),
  .rd_im(rd_im)
);

// File: tb/slice_corr_acc_tb_top.sv
`timescale 1ns/1ps
module slice_corr_acc_tb_top;
  localparam int N = 12, W = 16, AW = 40;
  localparam longint SMAX = (64'sd1 <<< 39) - 1;
  localparam longint SMIN = -(64'sd1 <<< 39);

  logic clk = 0, rst_n = 0, start = 0, clear = 0, in_valid = 0;
  logic [15:0] target = '0;
  logic [N*W-1:0] in_re = '0, in_im = '0;
  logic [3:0] rd_row = '0, rd_col = '0;
  logic in_ready, done;
  logic signed [AW-1:0] rd_re, rd_im;

  int checks = 0, fails = 0;
  longint m_re [N][N], m_im [N][N];
  int sr [N], si [N];
  int mrow = 0;

  always #10 clk = ~clk;

  slice_corr_acc dut_i (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat(longint v);
    return v > SMAX ? SMAX : (v < SMIN ? SMIN : v);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin m_re[i][j] = 0; m_im[i][j] = 0; end
    mrow = 0;
  endtask

  task automatic send_set();
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_re[i*W +: W] = 16'(sr[i]);
      in_im[i*W +: W] = 16'(si[i]);
    end
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R5 ready low after accept", in_ready, 0);
    for (int j = 0; j < N; j++) begin
      m_re[mrow][j] = sat(m_re[mrow][j] + longint'(sr[mrow])*sr[j] + longint'(si[mrow])*si[j]);
      m_im[mrow][j] = sat(m_im[mrow][j] + longint'(si[mrow])*sr[j] - longint'(sr[mrow])*si[j]);
    end
    mrow = (mrow + 1) % N;
  endtask

  task automatic pattern(int k);
    for (int i = 0; i < N; i++) begin
      sr[i] = ((k*7919 + i*1013) % 60001) - 30000;
      si[i] = ((k*4271 + i*2887 + 555) % 60001) - 30000;
    end
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_row = 4'(i); rd_col = 4'(j);
        @(negedge clk);
        chk({tag, " re"}, rd_re, m_re[i][j]);
        chk({tag, " im"}, rd_im, m_im[i][j]);
      end
  endtask

  task automatic do_start(int n);
    target = 16'(n); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic do_clear();
    clear = 1; @(negedge clk); clear = 0;
    model_clear();
  endtask

  task automatic t_reset();
    chk("R1 done after reset", done, 0);
    chk("R1 ready after reset", in_ready, 0);
    read_all("R1 zero matrix");
  endtask

  task automatic t_basic();
    do_start(14);
    chk("R2 ready after start", in_ready, 1);
    for (int k = 0; k < 14; k++) begin
      pattern(k);
      send_set();
      @(negedge clk);
      chk("R6 done only at target", done, k == 13);
    end
    read_all("R3 R4 products with row wrap");
  endtask

  task automatic t_ignore();
    pattern(99);
    for (int i = 0; i < N; i++) begin
      in_re[i*W +: W] = 16'(sr[i]); in_im[i*W +: W] = 16'(si[i]);
    end
    in_valid = 1;
    repeat (6) @(negedge clk);
    in_valid = 0;
    chk("R6 ready low while done", in_ready, 0);
    do_start(3);
    chk("R2 start ignored while done", in_ready, 0);
    read_all("R6 matrix unchanged after done");
  endtask

  task automatic t_clear();
    do_clear();
    chk("R8 done cleared", done, 0);
    read_all("R8 matrix zeroed");
    do_start(0);
    chk("R2 zero target done at once", done, 1);
    do_clear();
    do_start(2);
    pattern(5); send_set();
    pattern(6); send_set();
    @(negedge clk);
    read_all("R8 R4 row restarts at 0");
    rd_row = 4'd12; rd_col = 4'd3;
    @(negedge clk);
    chk("R9 out of range row", rd_re, 0);
    rd_row = 4'd0; rd_col = 4'd1;
    @(negedge clk);
    chk("R9 one cycle read", rd_re, m_re[0][1]);
    rd_row = 4'd1; rd_col = 4'd1;
    @(negedge clk);
    chk("R10 diag imag", rd_im, 0);
  endtask

  task automatic t_sat();
    do_clear();
    do_start(3 * 12 * 256);
    for (int i = 0; i < N; i++) begin sr[i] = -32768; si[i] = (i == 0) ? 32767 : -32768; end
    for (int k = 0; k < 3 * 12 * 256; k++) send_set();
    @(negedge clk);
    chk("R6 done after long run", done, 1);
    rd_row = 4'd2; rd_col = 4'd5;
    @(negedge clk);
    chk("R7 positive saturation", rd_re, SMAX);
    rd_row = 4'd0; rd_col = 4'd3;
    @(negedge clk);
    chk("R7 negative saturation", rd_im, m_im[0][3]);
    chk("R7 model saturated low", m_im[0][3], SMIN);
    read_all("R7 saturated matrix");
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignore();
    t_clear();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule